// File: doc/BRIEF.md
# Address-Matched Write Error Injector

This block sits in a memory controller's write path as a single pipeline stage. It corrupts chosen write transactions on purpose so that the error-correction logic downstream can be exercised. Each transaction carries a location word with DIMM, rank, bank, page and column fields. It also carries a 64-byte line of data, 64 check bits (32 for each 32-byte half) and an address parity bit. Every transaction leaves the block one cycle after it is accepted. Data is never altered. When injection is armed and a write matches the programmed location, the block XORs a 32-bit flip mask into the check bits of the chosen halves, inverts the parity bit, or does both.

Software programs the block through a small write-only register port. The port holds a 42-bit match word (two registers), the flip mask, a 5-bit control register and a strobe that clears the injected-error counter. The `armed` output shows whether injection is still live, which makes one-shot mode observable. `inj_count` gives the number of corrupted writes.

The flip mask sets the kind of error. Flipping bits inside one aligned 16-bit symbol pair gives a correctable error. Flipping bits in two pairs gives an uncorrectable one.

Top module: `wr_fault_injector`

## Requirements
- R1: After reset, `out_valid`, `armed` and `inj_count` are all 0.
- R2: Every accepted transaction appears on the outputs one cycle later. Data is always unchanged. Check bits and parity are also unchanged unless that write is injected.
- R3: Match word fields: column 13:0, page 29:14, bank 33:30. Wildcard bits disable single comparisons: 37 column, 38 page, 39 bank, 40 rank, 41 DIMM. Location word fields: column 13:0, page 29:14, bank 33:30, rank 35:34, DIMM 37:36. Register addresses: 0 writes match bits 31:0, 1 writes match bits 41:32, 2 writes the flip mask, 3 writes the control register, 4 clears the counter.
- R4: With `three_dimm` high, the match compares DIMM bits 1:0 against match bits 36:35, and rank bit 0 against match bit 34. With it low, it compares DIMM bit 0 against bit 36, and rank bits 1:0 against bits 35:34.
- R5: Control bit 0 is repeat, bits 2:1 are half-select, bit 3 is check-bit injection and bit 4 is parity injection. A control write with bit 3 or bit 4 set arms the block. A control write with neither bit set disarms it.
- R6: With repeat clear, exactly one matching write is corrupted, `armed` falls, and later writes pass clean.
- R7: With repeat set, every matching write is corrupted and `armed` stays high until a control write clears it.
- R8: Half-select 01 flips only check bits 31:0 (lower half). 10 flips only bits 63:32 (upper half). Both 11 and 00 flip both halves.
- R9: With control bit 4 set, an injected write has its parity bit inverted. With bit 3 clear, its check bits are unchanged.
- R10: A read transaction (`in_we` low) is never corrupted and does not consume a one-shot arming.
- R11: Writing a match or flip-mask register while armed disarms the block.
- R12: `inj_count` counts corrupted writes, saturates at 65535 and returns to 0 on a write to register 4.
- R13: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| three_dimm | input | 1 | Channel populated with three DIMMs |
| in_valid | input | 1 | Transaction valid |
| in_ready | output | 1 | Stage can accept a transaction |
| in_we | input | 1 | 1 = write, 0 = read |
| in_loc | input | 38 | Transaction location fields |
| in_data | input | 512 | Line data |
| in_ecc | input | 64 | Check bits, lower half in 31:0 |
| in_par | input | 1 | Address parity bit |
| out_valid | output | 1 | Output transaction valid |
| out_ready | input | 1 | Downstream accepts |
| out_we | output | 1 | Forwarded write flag |
| out_loc | output | 38 | Forwarded location |
| out_data | output | 512 | Forwarded data |
| out_ecc | output | 64 | Check bits, possibly corrupted |
| out_par | output | 1 | Parity bit, possibly inverted |
| armed | output | 1 | Injection live |
| inj_count | output | 16 | Saturating count of corrupted writes |

## Verification
The bound checker checks these behaviours on every cycle:
- Outputs hold under backpressure.
- Reads and unarmed transfers pass their check bits and parity through untouched.
- A one-shot injection drops `armed`.
- A parameter write disarms.
- The counter does not wrap past its maximum.

The field packing under both DIMM layouts, the per-field wildcards, the half-select patterns and the exact number of corrupted writes depend on programmed values. Only the bench's scenarios show these: a table of match cases, then directed sequences.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  parameter int COL_W   = 14;
  parameter int PAGE_W  = 16;
  parameter int BANK_W  = 4;
  parameter int RANK_W  = 2;
  parameter int DIMM_W  = 2;
  parameter int LOC_W   = COL_W + PAGE_W + BANK_W + RANK_W + DIMM_W;
  parameter int MATCH_W = 42;
  parameter int CTRL_W  = 5;
  parameter int NHALF   = 2;

  parameter int PAGE_LSB = COL_W;
  parameter int BANK_LSB = PAGE_LSB + PAGE_W;
  parameter int RANK_LSB = BANK_LSB + BANK_W;
  parameter int DIMM_LSB = RANK_LSB + RANK_W;

  parameter int WC_COL  = 37;
  parameter int WC_PAGE = 38;
  parameter int WC_BANK = 39;
  parameter int WC_RANK = 40;
  parameter int WC_DIMM = 41;

  parameter int CB_REPEAT = 0;
  parameter int CB_HALF   = 1;
  parameter int CB_ECC    = 3;
  parameter int CB_PAR    = 4;

  typedef enum logic [2:0] {
    RA_MATCH_LO = 3'd0,
    RA_MATCH_HI = 3'd1,
    RA_FLIP     = 3'd2,
    RA_CTRL     = 3'd3,
    RA_CLRCNT   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/wfi_cfg_regs.sv
module wfi_cfg_regs
  import wfi_pkg::*;
#(
  parameter int FLIP_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic               fire,
  output logic [MATCH_W-1:0] match_q,
  output logic [FLIP_W-1:0]  flip_q,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic               armed_q,
  output logic [CNT_W-1:0]   count_q
);
  localparam int HI_W = MATCH_W - 32;

  logic wr_param, wr_ctrl, wr_clr;
  assign wr_ctrl  = cfg_we && (cfg_addr == RA_CTRL);
  assign wr_clr   = cfg_we && (cfg_addr == RA_CLRCNT);
  assign wr_param = cfg_we && ((cfg_addr == RA_MATCH_LO) ||
                               (cfg_addr == RA_MATCH_HI) ||
                               (cfg_addr == RA_FLIP));

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      flip_q  <= '0;
      ctrl_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_MATCH_LO: match_q[31:0]        <= cfg_wdata;
        RA_MATCH_HI: match_q[MATCH_W-1:32] <= cfg_wdata[HI_W-1:0];
        RA_FLIP:     flip_q               <= cfg_wdata[FLIP_W-1:0];
        RA_CTRL:     ctrl_q               <= cfg_wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      armed_q <= 1'b0;
    else if (wr_ctrl)
      armed_q <= cfg_wdata[CB_ECC] | cfg_wdata[CB_PAR];
    else if (wr_param)
      armed_q <= 1'b0;
    else if (fire && !ctrl_q[CB_REPEAT])
      armed_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (wr_clr)
      count_q <= '0;
    else if (fire && (count_q != {CNT_W{1'b1}}))
      count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/wfi_addr_match.sv
module wfi_addr_match
  import wfi_pkg::*;
(
  input  logic               three_dimm,
  input  logic [MATCH_W-1:0] match_w,
  input  logic [LOC_W-1:0]   loc,
  output logic               hit
);
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic [BANK_W-1:0] bank;
  logic [RANK_W-1:0] rank;
  logic [DIMM_W-1:0] dimm;
  logic eq_col, eq_page, eq_bank, eq_rank, eq_dimm;

  assign col  = loc[COL_W-1:0];
  assign page = loc[PAGE_LSB +: PAGE_W];
  assign bank = loc[BANK_LSB +: BANK_W];
  assign rank = loc[RANK_LSB +: RANK_W];
  assign dimm = loc[DIMM_LSB +: DIMM_W];

  always_comb begin
    eq_col  = match_w[WC_COL]  || (col  == match_w[13:0]);
    eq_page = match_w[WC_PAGE] || (page == match_w[29:14]);
    eq_bank = match_w[WC_BANK] || (bank == match_w[33:30]);
    if (three_dimm) begin
      eq_rank = rank[0] == match_w[34];
      eq_dimm = dimm    == match_w[36:35];
    end else begin
      eq_rank = rank    == match_w[35:34];
      eq_dimm = dimm[0] == match_w[36];
    end
    eq_rank = eq_rank || match_w[WC_RANK];
    eq_dimm = eq_dimm || match_w[WC_DIMM];
    hit = eq_col && eq_page && eq_bank && eq_rank && eq_dimm;
  end
endmodule

// File: rtl/wfi_stage.sv
module wfi_stage
  import wfi_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int FLIP_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_we,
  input  logic [LOC_W-1:0]        in_loc,
  input  logic [DATA_W-1:0]       in_data,
  input  logic [NHALF*FLIP_W-1:0] in_ecc,
  input  logic                    in_par,
  input  logic                    fire,
  input  logic                    do_ecc,
  input  logic                    do_par,
  input  logic [1:0]              half_sel,
  input  logic [FLIP_W-1:0]       flip,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_we,
  output logic [LOC_W-1:0]        out_loc,
  output logic [DATA_W-1:0]       out_data,
  output logic [NHALF*FLIP_W-1:0] out_ecc,
  output logic                    out_par
);
  localparam int ECC_W = NHALF * FLIP_W;

  logic [ECC_W-1:0] flip_vec;
  logic             adv;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign flip_vec[h*FLIP_W +: FLIP_W] =
      (half_sel[h] || (half_sel == 2'b00)) ? flip : '0;
  end

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst)
      out_valid <= 1'b0;
    else if (adv)
      out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_we   <= in_we;
      out_loc  <= in_loc;
      out_data <= in_data;
      out_ecc  <= (fire && do_ecc) ? (in_ecc ^ flip_vec) : in_ecc;
      out_par  <= in_par ^ (fire && do_par);
    end
  end
endmodule

// File: rtl/wr_fault_injector.sv
module wr_fault_injector
  import wfi_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int FLIP_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_addr,
  input  logic [31:0]             cfg_wdata,
  input  logic                    three_dimm,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_we,
  input  logic [LOC_W-1:0]        in_loc,
  input  logic [DATA_W-1:0]       in_data,
  input  logic [NHALF*FLIP_W-1:0] in_ecc,
  input  logic                    in_par,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_we,
  output logic [LOC_W-1:0]        out_loc,
  output logic [DATA_W-1:0]       out_data,
  output logic [NHALF*FLIP_W-1:0] out_ecc,
  output logic                    out_par,
  output logic                    armed,
  output logic [CNT_W-1:0]        inj_count
);
  logic [MATCH_W-1:0] match_q;
  logic [FLIP_W-1:0]  flip_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               hit;
  logic               fire;

  wfi_cfg_regs #(.FLIP_W(FLIP_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fire(fire), .match_q(match_q),
    .flip_q(flip_q), .ctrl_q(ctrl_q), .armed_q(armed), .count_q(inj_count)
  );

  wfi_addr_match u_match (
    .three_dimm(three_dimm), .match_w(match_q), .loc(in_loc), .hit(hit)
  );

  assign fire = in_valid && in_ready && in_we && armed && hit;

  wfi_stage #(.DATA_W(DATA_W), .FLIP_W(FLIP_W)) u_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_we(in_we), .in_loc(in_loc), .in_data(in_data), .in_ecc(in_ecc),
    .in_par(in_par), .fire(fire), .do_ecc(ctrl_q[CB_ECC]),
    .do_par(ctrl_q[CB_PAR]), .half_sel(ctrl_q[CB_HALF +: 2]),
    .flip(flip_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_we(out_we), .out_loc(out_loc), .out_data(out_data),
    .out_ecc(out_ecc), .out_par(out_par)
  );
endmodule

// File: rtl/wfi_checker.sv
module wfi_checker
  import wfi_pkg::*;
#(
  parameter int FLIP_W = 32,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_we,
  input logic [2:0]              cfg_addr,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_we,
  input logic [NHALF*FLIP_W-1:0] in_ecc,
  input logic                    in_par,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [NHALF*FLIP_W-1:0] out_ecc,
  input logic                    out_par,
  input logic                    armed,
  input logic [CNT_W-1:0]        inj_count,
  input logic                    fire,
  input logic [CTRL_W-1:0]       ctrl_q
);
  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R13

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ecc) && $stable(out_par))); // R13

  AST_READ_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_we) |=>
      (out_ecc == $past(in_ecc) && out_par == $past(in_par))); // R10

  AST_UNARMED_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !armed) |=>
      (out_ecc == $past(in_ecc) && out_par == $past(in_par))); // R2

  AST_ONESHOT_DROP: assert property (@(posedge clk) disable iff (rst)
    (fire && !ctrl_q[CB_REPEAT] && !cfg_we) |=> !armed); // R6

  AST_PARAM_DISARM: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_addr == RA_MATCH_LO || cfg_addr == RA_MATCH_HI ||
                cfg_addr == RA_FLIP)) |=> !armed); // R11

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((inj_count == {CNT_W{1'b1}}) && !(cfg_we && cfg_addr == RA_CLRCNT))
      |=> (inj_count == {CNT_W{1'b1}})); // R12
endmodule

bind wr_fault_injector wfi_checker #(.FLIP_W(FLIP_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .in_valid(in_valid), .in_ready(in_ready), .in_we(in_we),
  .in_ecc(in_ecc), .in_par(in_par), .out_valid(out_valid),
  .out_ready(out_ready), .out_ecc(out_ecc), .out_par(out_par),
  .armed(armed), .inj_count(inj_count), .fire(fire), .ctrl_q(ctrl_q)
);

// File: tb/wr_fault_injector_test.sv
module wr_fault_injector_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 512;
  localparam int LW = 38;

  typedef struct packed {
    logic        three;
    logic [4:0]  wc;     // bit0 col, 1 page, 2 bank, 3 rank, 4 dimm
    logic [1:0]  d;
    logic [1:0]  r;
    logic [3:0]  b;
    logic [15:0] p;
    logic [13:0] c;
    logic        hit;
  } vec_t;

  // Transaction location used by the table: dimm 1, rank 2, bank 5, page 1234, col 0abc
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc, 1'b1},
    '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abd, 1'b0},
    '{1'b0, 5'h01, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abd, 1'b1},
    '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1235, 14'h0abc, 1'b0},
    '{1'b0, 5'h02, 2'd1, 2'd2, 4'd5, 16'h1235, 14'h0abc, 1'b1},
    '{1'b0, 5'h00, 2'd1, 2'd2, 4'd6, 16'h1234, 14'h0abc, 1'b0},
    '{1'b0, 5'h04, 2'd1, 2'd2, 4'd6, 16'h1234, 14'h0abc, 1'b1},
    '{1'b0, 5'h00, 2'd1, 2'd3, 4'd5, 16'h1234, 14'h0abc, 1'b0},
    '{1'b0, 5'h08, 2'd1, 2'd3, 4'd5, 16'h1234, 14'h0abc, 1'b1},
    '{1'b0, 5'h00, 2'd3, 2'd2, 4'd5, 16'h1234, 14'h0abc, 1'b1},
    '{1'b0, 5'h00, 2'd0, 2'd2, 4'd5, 16'h1234, 14'h0abc, 1'b0},
    '{1'b0, 5'h10, 2'd0, 2'd2, 4'd5, 16'h1234, 14'h0abc, 1'b1},
    '{1'b1, 5'h00, 2'd1, 2'd0, 4'd5, 16'h1234, 14'h0abc, 1'b1},
    '{1'b1, 5'h00, 2'd3, 2'd2, 4'd5, 16'h1234, 14'h0abc, 1'b0},
    '{1'b1, 5'h00, 2'd1, 2'd1, 4'd5, 16'h1234, 14'h0abc, 1'b0},
    '{1'b0, 5'h1f, 2'd2, 2'd1, 4'd9, 16'h4321, 14'h0123, 1'b1}
  };

  logic clk = 1'b0;
  logic rst;
  logic cfg_we;
  logic [2:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic three_dimm;
  logic in_valid, in_ready, in_we, in_par;
  logic [LW-1:0] in_loc;
  logic [DW-1:0] in_data;
  logic [63:0] in_ecc;
  logic out_valid, out_ready, out_we, out_par, armed;
  logic [LW-1:0] out_loc;
  logic [DW-1:0] out_data;
  logic [63:0] out_ecc;
  logic [15:0] inj_count;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_fault_injector uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .three_dimm(three_dimm), .in_valid(in_valid),
    .in_ready(in_ready), .in_we(in_we), .in_loc(in_loc), .in_data(in_data),
    .in_ecc(in_ecc), .in_par(in_par), .out_valid(out_valid),
    .out_ready(out_ready), .out_we(out_we), .out_loc(out_loc),
    .out_data(out_data), .out_ecc(out_ecc), .out_par(out_par),
    .armed(armed), .inj_count(inj_count)
  );

  function automatic logic [LW-1:0] mkloc(logic [1:0] d, logic [1:0] r,
      logic [3:0] b, logic [15:0] p, logic [13:0] c);
    return {d, r, b, p, c};
  endfunction

  function automatic logic [41:0] mkmatch(vec_t v);
    logic [41:0] m;
    m = '0;
    m[13:0]  = v.c;
    m[29:14] = v.p;
    m[33:30] = v.b;
    if (v.three) begin
      m[34]    = v.r[0];
      m[36:35] = v.d;
    end else begin
      m[35:34] = v.r;
      m[36]    = v.d[0];
    end
    m[41:37] = v.wc;
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_match(logic [41:0] m);
    cfg(3'd0, m[31:0]);
    cfg(3'd1, {22'd0, m[41:32]});
  endtask

  // Drive one transaction; outputs are sampled at the next falling edge.
  task automatic send(logic we, logic [63:0] ecc, logic par, logic [DW-1:0] dat);
    @(negedge clk);
    in_valid = 1'b1; in_we = we; in_ecc = ecc; in_par = par; in_data = dat;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  localparam logic [LW-1:0] BASE = {2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc};
  localparam logic [41:0] WILD = 42'h3e0_0000_0000;

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    three_dimm = 1'b0; in_valid = 1'b0; in_we = 1'b0; in_par = 1'b0;
    in_loc = BASE; in_data = '0; in_ecc = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 armed", {63'd0, armed}, 64'd0);
    chk("R1 count", {48'd0, inj_count}, 64'd0);

    // R2 passthrough while unarmed
    send(1'b1, 64'h1111_2222_3333_4444, 1'b1, {16{32'hdead_beef}});
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
    chk("R2 data", {63'd0, out_data == {16{32'hdead_beef}}}, 64'd1);
    chk("R2 ecc", out_ecc, 64'h1111_2222_3333_4444);
    chk("R2 loc", {26'd0, out_loc}, {26'd0, BASE});

    // R3/R4 match table
    cfg(3'd2, 32'h8000_0001);
    for (int i = 0; i < NV; i++) begin
      three_dimm = VEC[i].three;
      program_match(mkmatch(VEC[i]));
      cfg(3'd3, 32'h0f);
      send(1'b1, 64'h0, 1'b0, '0);
      chk(VEC[i].three ? "R4 table" : "R3 table", out_ecc,
          VEC[i].hit ? 64'h8000_0001_8000_0001 : 64'h0);
      cfg(3'd3, 32'h0);
    end
    three_dimm = 1'b0;

    // R8 half select, all fields wildcarded
    program_match(WILD);
    cfg(3'd2, 32'h0000_00ff);
    cfg(3'd3, 32'h0b);  // repeat, half 01, ecc
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R8 lower", out_ecc, 64'h0000_0000_0000_00ff);
    cfg(3'd3, 32'h0d);  // half 10
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R8 upper", out_ecc, 64'h0000_00ff_0000_0000);
    cfg(3'd3, 32'h0f);  // half 11
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R8 whole", out_ecc, 64'h0000_00ff_0000_00ff);
    cfg(3'd3, 32'h09);  // half 00
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R8 none", out_ecc, 64'h0000_00ff_0000_00ff);

    // R10 reads pass clean and keep the arming
    send(1'b0, 64'h5, 1'b1, '0);
    chk("R10 ecc", out_ecc, 64'h5);
    chk("R10 par", {63'd0, out_par}, 64'd1);
    chk("R10 armed", {63'd0, armed}, 64'd1);

    // R9 parity only
    cfg(3'd3, 32'h11);
    send(1'b1, 64'h7, 1'b0, '0);
    chk("R9 par", {63'd0, out_par}, 64'd1);
    chk("R9 ecc", out_ecc, 64'h7);

    // R5 control without ecc/parity bits does not arm
    cfg(3'd3, 32'h07);
    chk("R5 no arm", {63'd0, armed}, 64'd0);
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R5 clean", out_ecc, 64'h0);

    // R6 one-shot
    cfg(3'd4, 32'h0);
    chk("R12 clear", {48'd0, inj_count}, 64'd0);
    cfg(3'd3, 32'h08);
    chk("R5 arm", {63'd0, armed}, 64'd1);
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R6 first", out_ecc, 64'h0000_00ff_0000_00ff);
    chk("R6 disarmed", {63'd0, armed}, 64'd0);
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R6 second clean", out_ecc, 64'h0);

    // R7 repeat
    cfg(3'd3, 32'h09);
    for (int k = 0; k < 3; k++) begin
      send(1'b1, 64'h0, 1'b0, '0);
      chk("R7 repeat", out_ecc, 64'h0000_00ff_0000_00ff);
    end
    chk("R7 still armed", {63'd0, armed}, 64'd1);
    chk("R12 count", {48'd0, inj_count}, 64'd4);
    cfg(3'd3, 32'h0);
    chk("R7 cleared", {63'd0, armed}, 64'd0);
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R7 clean after clear", out_ecc, 64'h0);

    // R11 parameter write disarms
    cfg(3'd3, 32'h09);
    cfg(3'd2, 32'h0000_00ff);
    chk("R11 disarm", {63'd0, armed}, 64'd0);
    send(1'b1, 64'h0, 1'b0, '0);
    chk("R11 clean", out_ecc, 64'h0);

    // R13 backpressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_we = 1'b0; in_ecc = 64'haa; in_par = 1'b0;
    @(negedge clk);
    chk("R13 first out", out_ecc, 64'haa);
    chk("R13 ready low", {63'd0, in_ready}, 64'd0);
    in_ecc = 64'hbb;
    @(negedge clk);
    @(negedge clk);
    chk("R13 held", out_ecc, 64'haa);
    chk("R13 valid held", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R13 second out", out_ecc, 64'hbb);
    in_valid = 1'b0;
    @(negedge clk);

    // R12 saturation
    cfg(3'd3, 32'h09);
    @(negedge clk);
    in_valid = 1'b1; in_we = 1'b1; in_ecc = '0;
    repeat (65540) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 saturate", {48'd0, inj_count}, 64'd65535);
    cfg(3'd4, 32'h0);
    chk("R12 clear after sat", {48'd0, inj_count}, 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule